// File: doc/BRIEF.md
# Two-Source Redirect Epoch Controller

This block is the control skeleton of a fetch / decode / execute pipeline in which both the decode stage and the execute stage may steer the program counter. Instructions travel as tokens that carry their own PC, the predicted next PC and two one-bit epoch tags. Fetch tags every token with its estimates of the execute epoch and of the decode epoch. Decode and execute compare those tags with epoch registers of their own. Tokens from a squashed path are dropped at decode or poisoned at execute, and decode redirects that were issued on a path execute has already abandoned are discarded.

Execute redirects always win. Each redirect channel is a single-entry bypass queue, so fetch sees a message in the cycle it is raised. A cycle in which fetch consumes a redirect fetches nothing. The fetch-to-decode path is `F2D_DEPTH` register stages deep, so a token fetched in cycle t is presented to decode in cycle t+F2D_DEPTH and to execute one cycle later. The surrounding pipeline supplies the next-address guess at fetch, the direction-based target at decode and the resolved next PC at execute.

Top module: `redirect_epoch_ctl`

## Requirements
- R1: After reset the fetch PC equals RESET_PC, no token is valid at decode or execute, and every epoch register is 0.
- R2: With no redirect, fetch issues one token per cycle and loads `fetch_pred_pc` as its next PC. A token fetched in cycle t appears at decode in cycle t+F2D_DEPTH and at execute in cycle t+F2D_DEPTH+1.
- R3: A valid, non-poisoned execute token whose `exe_next_pc` differs from its predicted PC raises `exe_redirect`. In the next cycle the fetch PC equals `exe_next_pc`, and fetch issues no token in the redirect cycle.
- R4: When execute and decode both raise a redirect in the same cycle, the execute target is loaded and the decode message is kept for the following cycle.
- R5: A decode redirect whose carried execute tag equals fetch's execute-epoch estimate loads the decode target as the next fetch PC. Fetch issues no token in the cycle it consumes the message.
- R6: A decode redirect whose carried execute tag differs from fetch's estimate is consumed without effect. The fetch PC keeps its value for that cycle, then fetching resumes from it.
- R7: A decode token whose execute tag matches decode's execute epoch but whose decode tag differs from the decode epoch is dropped (`dec_accept`=0) and never reaches execute.
- R8: A decode token whose execute tag differs from decode's execute epoch is accepted. Decode adopts both of its tags as its epochs, and it may still raise a redirect that fetch applies.
- R9: An execute token whose execute tag differs from the execute epoch is presented with `exe_poison`=1 and `exe_valid`=1 and never raises a redirect.
- R10: An accepted decode token is forwarded to execute with decode's own target as its predicted PC, so a decode-corrected branch causes no execute redirect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fetch_pred_pc | input | PC_W | Next-address guess for `fetch_pc` |
| dec_pred_pc | input | PC_W | Decode's target for the token at `dec_pc` |
| exe_next_pc | input | PC_W | Resolved next PC for the token at `exe_pc` |
| fetch_pc | output | PC_W | PC fetched this cycle |
| dec_valid | output | 1 | A token is present at decode |
| dec_pc | output | PC_W | PC of the decode token |
| dec_accept | output | 1 | Decode token is kept (not dropped) |
| dec_redirect | output | 1 | Decode raises a redirect this cycle |
| exe_valid | output | 1 | A token is present at execute |
| exe_pc | output | PC_W | PC of the execute token |
| exe_ppc | output | PC_W | Predicted next PC of the execute token |
| exe_poison | output | 1 | Execute token is from a squashed path |
| exe_redirect | output | 1 | Execute raises a redirect this cycle |

## Verification
The bench first runs a straight-line stream with no redirects. This separates correct pipe latency and sequential PC advance from any redirect effect. A lone decode redirect shows the bubble, the drop of the one wrong-path token in flight and a clean execute pass. A lone execute redirect, followed by a decode redirect on the first new-path token, shows poisoning of every in-flight token, epoch adoption at decode and a second, accepted redirect. A collision of both redirects in one cycle tells priority apart from the discard of the stale decode message: a wrong design would load the decode target one cycle later.

// File: rtl/rdr_pkg.sv
package rdr_pkg;
  parameter int unsigned PC_W = 32;

  typedef logic [PC_W-1:0] pc_t;

  // token flowing down the pipe
  typedef struct packed {
    logic vld;
    pc_t  pc;
    pc_t  ppc;
    logic etag;
    logic dtag;
  } tok_t;

  // decode-to-fetch redirect message
  typedef struct packed {
    logic vld;
    pc_t  tgt;
    logic etag;
  } dmsg_t;

  function automatic logic tag_stale(input logic tag, input logic own);
    return tag != own;
  endfunction

  function automatic logic pc_differs(input pc_t guess, input pc_t truth);
    return guess != truth;
  endfunction
endpackage

// File: rtl/rdr_fetch.sv
module rdr_fetch
  import rdr_pkg::*;
#(
  parameter pc_t         RESET_PC = '0,
  parameter int unsigned DEPTH    = 2
) (
  input  logic  clk,
  input  logic  rst_n,
  input  pc_t   pred_pc,
  input  logic  exe_fire,
  input  pc_t   exe_tgt,
  input  dmsg_t dec_msg,
  output pc_t   pc_o,
  output tok_t  tok_o
);
  pc_t   pc_q;
  logic  fe_q, fd_q;
  dmsg_t dq_q;
  tok_t  pipe [DEPTH];

  // named events
  dmsg_t dq_head;
  logic  dq_take, dq_apply, fetch_en;

  always_comb begin
    dq_head  = dq_q.vld ? dq_q : dec_msg;
    dq_take  = !exe_fire && dq_head.vld;
    dq_apply = dq_take && !tag_stale(dq_head.etag, fe_q);
    fetch_en = !exe_fire && !dq_take;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pc_q <= RESET_PC;
      fe_q <= 1'b0;
      fd_q <= 1'b0;
      dq_q <= '0;
    end else if (exe_fire) begin
      pc_q <= exe_tgt;
      fe_q <= ~fe_q;
      if (dec_msg.vld) dq_q <= dec_msg;
    end else if (dq_take) begin
      if (dq_apply) begin
        pc_q <= dq_head.tgt;
        fd_q <= ~fd_q;
      end
      dq_q <= '0;
    end else begin
      pc_q <= pred_pc;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) pipe[0] <= '0;
    else if (fetch_en) pipe[0] <= '{vld: 1'b1, pc: pc_q, ppc: pred_pc, etag: fe_q, dtag: fd_q};
    else pipe[0] <= '0;
  end

  for (genvar i = 1; i < DEPTH; i++) begin : g_stage
    always_ff @(posedge clk) begin
      if (!rst_n) pipe[i] <= '0;
      else pipe[i] <= pipe[i-1];
    end
  end

  assign pc_o  = pc_q;
  assign tok_o = pipe[DEPTH-1];

  assert_exe_first_R4: assert property (@(posedge clk) disable iff (!rst_n)
    exe_fire |=> (pc_q == $past(exe_tgt)));
  assert_no_fetch_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (exe_fire || dq_head.vld) |=> !pipe[0].vld);
  assert_single_msg_R6: assert property (@(posedge clk) disable iff (!rst_n)
    dq_q.vld |-> !dec_msg.vld);
  assert_stale_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (dq_take && !dq_apply) |=> ($stable(pc_q) && $stable(fd_q)));
endmodule

// File: rtl/rdr_decode.sv
module rdr_decode
  import rdr_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  tok_t  tok_i,
  input  pc_t   dir_pc,
  output tok_t  tok_o,
  output dmsg_t msg_o,
  output logic  accept_o,
  output logic  fire_o
);
  logic de_q, d_q;
  tok_t d2e_q;

  // named events
  logic new_path, drop, accept, fire;

  always_comb begin
    new_path = tok_i.vld && tag_stale(tok_i.etag, de_q);
    drop     = tok_i.vld && !new_path && tag_stale(tok_i.dtag, d_q);
    accept   = tok_i.vld && !drop;
    fire     = accept && pc_differs(tok_i.ppc, dir_pc);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      de_q  <= 1'b0;
      d_q   <= 1'b0;
      d2e_q <= '0;
    end else begin
      if (new_path) begin
        de_q <= tok_i.etag;
        d_q  <= fire ? ~tok_i.dtag : tok_i.dtag;
      end else if (fire) begin
        d_q <= ~d_q;
      end
      if (accept) d2e_q <= '{vld: 1'b1, pc: tok_i.pc, ppc: dir_pc, etag: tok_i.etag, dtag: tok_i.dtag};
      else d2e_q <= '0;
    end
  end

  assign tok_o    = d2e_q;
  assign msg_o    = '{vld: fire, tgt: dir_pc, etag: tok_i.etag};
  assign accept_o = accept;
  assign fire_o   = fire;

  assert_drop_gone_R7: assert property (@(posedge clk) disable iff (!rst_n)
    drop |=> !d2e_q.vld);
  assert_adopt_R8: assert property (@(posedge clk) disable iff (!rst_n)
    new_path |=> (de_q == $past(tok_i.etag)));
endmodule

// File: rtl/rdr_execute.sv
module rdr_execute
  import rdr_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  tok_t tok_i,
  input  pc_t  actual_pc,
  output logic poison_o,
  output logic fire_o
);
  logic e_q;
  logic poison, fire;

  always_comb begin
    poison = tok_i.vld && tag_stale(tok_i.etag, e_q);
    fire   = tok_i.vld && !poison && pc_differs(tok_i.ppc, actual_pc);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) e_q <= 1'b0;
    else if (fire) e_q <= ~e_q;
  end

  assign poison_o = poison;
  assign fire_o   = fire;

  assert_poison_keeps_R9: assert property (@(posedge clk) disable iff (!rst_n)
    poison |=> $stable(e_q));
endmodule

// File: rtl/redirect_epoch_ctl.sv
module redirect_epoch_ctl
  import rdr_pkg::*;
#(
  parameter pc_t         RESET_PC  = '0,
  parameter int unsigned F2D_DEPTH = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [PC_W-1:0] fetch_pred_pc,
  input  logic [PC_W-1:0] dec_pred_pc,
  input  logic [PC_W-1:0] exe_next_pc,
  output logic [PC_W-1:0] fetch_pc,
  output logic            dec_valid,
  output logic [PC_W-1:0] dec_pc,
  output logic            dec_accept,
  output logic            dec_redirect,
  output logic            exe_valid,
  output logic [PC_W-1:0] exe_pc,
  output logic [PC_W-1:0] exe_ppc,
  output logic            exe_poison,
  output logic            exe_redirect
);
  tok_t  f2d_tok, d2e_tok;
  dmsg_t dec_msg;
  logic  exe_fire;

  rdr_fetch #(.RESET_PC(RESET_PC), .DEPTH(F2D_DEPTH)) u_fetch (
    .clk(clk), .rst_n(rst_n), .pred_pc(fetch_pred_pc),
    .exe_fire(exe_fire), .exe_tgt(exe_next_pc), .dec_msg(dec_msg),
    .pc_o(fetch_pc), .tok_o(f2d_tok)
  );

  rdr_decode u_decode (
    .clk(clk), .rst_n(rst_n), .tok_i(f2d_tok), .dir_pc(dec_pred_pc),
    .tok_o(d2e_tok), .msg_o(dec_msg), .accept_o(dec_accept), .fire_o(dec_redirect)
  );

  rdr_execute u_execute (
    .clk(clk), .rst_n(rst_n), .tok_i(d2e_tok), .actual_pc(exe_next_pc),
    .poison_o(exe_poison), .fire_o(exe_fire)
  );

  assign dec_valid    = f2d_tok.vld;
  assign dec_pc       = f2d_tok.pc;
  assign exe_valid    = d2e_tok.vld;
  assign exe_pc       = d2e_tok.pc;
  assign exe_ppc      = d2e_tok.ppc;
  assign exe_redirect = exe_fire;

  assert_exe_target_R3: assert property (@(posedge clk) disable iff (!rst_n)
    exe_redirect |=> (fetch_pc == $past(exe_next_pc)));
  assert_reset_empty_R1: assert property (@(posedge clk)
    !rst_n |=> (!dec_valid && !exe_valid && fetch_pc == RESET_PC));
endmodule

// File: tb/redirect_epoch_ctl_bench.sv
`timescale 1ns/1ps
module redirect_epoch_ctl_bench;
  import rdr_pkg::*;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  pc_t  fetch_pred_pc, dec_pred_pc, exe_next_pc;
  pc_t  fetch_pc, dec_pc, exe_pc, exe_ppc;
  logic dec_valid, dec_accept, dec_redirect;
  logic exe_valid, exe_poison, exe_redirect;

  localparam pc_t NONE = 32'hFFFF_FFF0;
  pc_t dm0 = NONE, dt0 = NONE, dm1 = NONE, dt1 = NONE;
  pc_t em0 = NONE, et0 = NONE, em1 = NONE, et1 = NONE;

  int unsigned n_run = 0, n_fail = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  // environment: sequential guess at fetch, small target maps at decode and execute
  assign fetch_pred_pc = fetch_pc + 32'd4;
  assign dec_pred_pc = (dec_pc == dm0) ? dt0 : (dec_pc == dm1) ? dt1 : dec_pc + 32'd4;
  assign exe_next_pc = (exe_pc == em0) ? et0 : (exe_pc == em1) ? et1 : exe_pc + 32'd4;

  redirect_epoch_ctl u_redirect_epoch_ctl (
    .clk(clk), .rst_n(rst_n), .fetch_pred_pc(fetch_pred_pc), .dec_pred_pc(dec_pred_pc),
    .exe_next_pc(exe_next_pc), .fetch_pc(fetch_pc), .dec_valid(dec_valid), .dec_pc(dec_pc),
    .dec_accept(dec_accept), .dec_redirect(dec_redirect), .exe_valid(exe_valid),
    .exe_pc(exe_pc), .exe_ppc(exe_ppc), .exe_poison(exe_poison), .exe_redirect(exe_redirect)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic restart();
    rst_n = 1'b0;
    step();
    step();
    rst_n = 1'b1;
    // cycle 0 is the state sampled here
  endtask

  task automatic clear_maps();
    dm0 = NONE; dt0 = NONE; dm1 = NONE; dt1 = NONE;
    em0 = NONE; et0 = NONE; em1 = NONE; et1 = NONE;
  endtask

  initial begin
    @(negedge clk);
    // scenario 1: straight-line stream
    clear_maps();
    restart();
    check("R1 fetch_pc", fetch_pc, 0);
    check("R1 dec_valid", dec_valid, 0);
    check("R1 exe_valid", exe_valid, 0);
    for (int n = 1; n <= 8; n++) begin
      step();
      check("R2 fetch_pc", fetch_pc, 4 * n);
      if (n >= 2) begin
        check("R2 dec_pc", dec_pc, 4 * (n - 2));
        check("R2 dec_accept", dec_accept, 1);
      end
      if (n >= 3) begin
        check("R2 exe_pc", exe_pc, 4 * (n - 3));
        check("R2 exe_redirect", exe_redirect, 0);
      end
    end

    // scenario 2: decode corrects pc 8 -> 100, execute agrees
    clear_maps();
    dm0 = 8; dt0 = 100; em0 = 8; et0 = 100;
    restart();
    repeat (4) step();
    check("R5 dec_redirect c4", dec_redirect, 1);
    check("R5 exe_redirect c4", exe_redirect, 0);
    step();
    check("R5 fetch_pc c5", fetch_pc, 100);
    check("R7 dec_pc c5", dec_pc, 12);
    check("R7 dec_accept c5", dec_accept, 0);
    check("R10 exe_ppc c5", exe_ppc, 100);
    check("R10 exe_redirect c5", exe_redirect, 0);
    step();
    check("R7 exe_valid c6", exe_valid, 0);
    step();
    check("R5 dec_pc c7", dec_pc, 100);
    check("R5 dec_accept c7", dec_accept, 1);
    step();
    check("R10 exe_pc c8", exe_pc, 100);
    check("R10 exe_poison c8", exe_poison, 0);

    // scenario 3: execute redirect 8 -> 200, then decode redirect 200 -> 400
    clear_maps();
    em0 = 8; et0 = 200; dm0 = 200; dt0 = 400; em1 = 200; et1 = 400;
    restart();
    repeat (5) step();
    check("R3 exe_redirect c5", exe_redirect, 1);
    check("R3 exe_pc c5", exe_pc, 8);
    step();
    check("R3 fetch_pc c6", fetch_pc, 200);
    check("R9 exe_pc c6", exe_pc, 12);
    check("R9 exe_poison c6", exe_poison, 1);
    check("R9 exe_valid c6", exe_valid, 1);
    check("R9 exe_redirect c6", exe_redirect, 0);
    step();
    check("R9 exe_poison c7", exe_poison, 1);
    check("R3 dec_valid c7", dec_valid, 0);
    step();
    check("R9 exe_valid c8", exe_valid, 0);
    check("R8 dec_pc c8", dec_pc, 200);
    check("R8 dec_accept c8", dec_accept, 1);
    check("R8 dec_redirect c8", dec_redirect, 1);
    step();
    check("R8 fetch_pc c9", fetch_pc, 400);
    check("R7 dec_accept c9", dec_accept, 0);
    check("R10 exe_pc c9", exe_pc, 200);
    check("R10 exe_redirect c9", exe_redirect, 0);
    step();
    step();
    check("R8 dec_pc c11", dec_pc, 400);
    check("R8 dec_accept c11", dec_accept, 1);

    // scenario 4: both stages redirect in one cycle
    clear_maps();
    em0 = 8; et0 = 200; dm0 = 12; dt0 = 300;
    restart();
    repeat (5) step();
    check("R4 exe_redirect c5", exe_redirect, 1);
    check("R4 dec_redirect c5", dec_redirect, 1);
    step();
    check("R4 fetch_pc c6", fetch_pc, 200);
    check("R7 dec_accept c6", dec_accept, 0);
    check("R9 exe_poison c6", exe_poison, 1);
    step();
    check("R6 fetch_pc c7", fetch_pc, 200);
    step();
    check("R6 fetch_pc c8", fetch_pc, 204);
    step();
    check("R8 dec_pc c9", dec_pc, 200);
    check("R8 dec_accept c9", dec_accept, 1);
    step();
    check("R6 exe_pc c10", exe_pc, 200);
    check("R6 exe_poison c10", exe_poison, 0);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #(5.0 * 20000);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule